// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is the register-transfer half of a small accumulator machine. It holds an address register, a program counter, a memory buffer, an accumulator, an instruction register and 16-bit input and output registers. All of them meet on one shared 16-bit bus. Each clock a controller picks one bus driver with a 3-bit source code and one bus receiver with a 3-bit destination code. Both codes are decoded into eight one-hot enables. The memory read data port is one of the drivers, and a memory write strobe is one of the receivers. The memory array itself sits outside the block.

Next to the bus, a few direct paths let the accumulator take a new value in the same cycle as an unrelated bus transfer. That value is the ALU result (AC with MBR), the MBR contents, or the constant one. The program counter has its own incrementer, so it can step without using the bus. The controller gets back the sign and zero state of the accumulator and the top four bits of the instruction register.

Top module: `busdp_top`

## Requirements
- R1: After reset, every register holds zero. The bench sees acZero=1, acNeg=0, opcode=0, memAddr=0, memWe=0 and outWord=0.
- R2: The source code picks the bus driver: 0 zero, 1 MAR, 2 PC, 3 MBR, 4 AC, 5 IR, 6 memRdData, 7 input register. With source 0 the bus carries 0.
- R3: The destination code picks the one receiver that captures the bus at the next rising edge: 1 MAR, 2 PC, 3 MBR, 4 AC, 5 IR, 6 memory write, 7 output register. Registers that are not selected keep their value.
- R4: MAR and PC are 12 bits wide. On the bus they are zero-extended. When they load from the bus they take bus bits 11..0.
- R5: acSel picks the accumulator's next value. 0 means the bus, loaded only when the destination is 4. 1 means the ALU result. 2 means MBR. 3 means the constant 1. The ALU with aluOp 0 passes MBR, with 1 gives AC+MBR, with 2 gives AC-MBR, and with 3 passes MBR. All arithmetic is modulo 2^16.
- R6: A nonzero acSel loads AC in that cycle no matter what the bus carries or which destination is chosen. A bus transfer whose source is AC places the old AC value on the bus.
- R7: pcInc adds one to PC modulo 4096 at the next edge. If destination 2 is chosen in the same cycle, the bus load wins.
- R8: While destination 6 is chosen, memWe is 1, memWrData equals the bus and memAddr equals MAR. Otherwise memWe is 0.
- R9: acNeg equals AC bit 15 and acZero is 1 exactly when AC is 0.
- R10: opcode equals IR bits 15..12.
- R11: The input register captures inWord at every rising edge.
- R12: Destination 0 changes no register and raises no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | 3 | Bus source code |
| dstSel | input | 3 | Bus destination code |
| aluOp | input | 2 | ALU operation |
| acSel | input | 2 | Accumulator input select |
| pcInc | input | 1 | Program counter increment strobe |
| memRdData | input | 16 | Data read from memory at memAddr |
| inWord | input | 16 | Value sampled by the input register |
| memAddr | output | 12 | Memory address (MAR) |
| memWe | output | 1 | Memory write strobe |
| memWrData | output | 16 | Memory write data (bus value) |
| outWord | output | 16 | Output register contents |
| acNeg | output | 1 | Accumulator is negative |
| acZero | output | 1 | Accumulator is zero |
| opcode | output | 4 | Upper four bits of IR |

## Verification
The bench builds the block with its default 16-bit data and 12-bit address widths. At these widths the bench can put several patterns into every register, including values whose upper nibble is set, so zero-extension and truncation of MAR and PC show up at the ports. At the same widths the ALU sweep covers every operation code with both carry-out and borrow operands, and PC wrap at 4095 takes only two increments.

// File: rtl/busdp_pkg.sv
`timescale 1ns/1ps
package busdp_pkg;
  localparam int SEL_W = 3;
  localparam int SEL_N = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SRC_ZERO, SRC_MAR, SRC_PC, SRC_MBR, SRC_AC, SRC_IR, SRC_MEM, SRC_IN
  } srcCode_e;

  typedef enum logic [SEL_W-1:0] {
    DST_NONE, DST_MAR, DST_PC, DST_MBR, DST_AC, DST_IR, DST_MEM, DST_OUT
  } dstCode_e;

  typedef enum logic [1:0] {ALU_PASS, ALU_ADD, ALU_SUB, ALU_PASSB} aluOp_e;
  typedef enum logic [1:0] {AC_BUS, AC_ALU, AC_MBR, AC_ONE} acSel_e;

  typedef struct packed {
    logic [SEL_N-1:0] srcEn;
    logic [SEL_N-1:0] dstEn;
    aluOp_e           aluOp;
    acSel_e           acSel;
    logic             pcInc;
  } busCtl_t;
endpackage

// File: rtl/busdp_ctrl.sv
`timescale 1ns/1ps
module busdp_ctrl
  import busdp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] srcSel,
  input  logic [SEL_W-1:0] dstSel,
  input  logic [1:0]       aluOp,
  input  logic [1:0]       acSel,
  input  logic             pcInc,
  output busCtl_t          ctl
);
  logic [SEL_N-1:0] srcOh;
  logic [SEL_N-1:0] dstOh;

  for (genvar g = 0; g < SEL_N; g++) begin : g_dec
    assign srcOh[g] = (srcSel == SEL_W'(g));
    assign dstOh[g] = (dstSel == SEL_W'(g));
  end

  always_comb begin
    ctl.srcEn = srcOh;
    ctl.dstEn = dstOh;
    ctl.aluOp = aluOp_e'(aluOp);
    ctl.acSel = acSel_e'(acSel);
    ctl.pcInc = pcInc;
  end

  // R2: exactly one bus driver each cycle
  assert_one_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(ctl.srcEn));
  // R3: at most one receiver each cycle
  assert_one_receiver_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.dstEn));
endmodule

// File: rtl/busdp_path.sv
`timescale 1ns/1ps
module busdp_path
  import busdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] inWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] outWord,
  output logic              acNeg,
  output logic              acZero,
  output logic [DATA_W-ADDR_W-1:0] opcode
);
  localparam int OP_W  = DATA_W - ADDR_W;
  localparam int EXT_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] mar, pc;
  logic [DATA_W-1:0] mbr, ac, ir, inReg, outReg;
  logic [DATA_W-1:0] srcVal [SEL_N];
  logic [DATA_W-1:0] busVal, aluRes, acNext;
  logic              acLoad;

  assign srcVal[int'(SRC_ZERO)] = '0;
  assign srcVal[int'(SRC_MAR)]  = {{EXT_W{1'b0}}, mar};
  assign srcVal[int'(SRC_PC)]   = {{EXT_W{1'b0}}, pc};
  assign srcVal[int'(SRC_MBR)]  = mbr;
  assign srcVal[int'(SRC_AC)]   = ac;
  assign srcVal[int'(SRC_IR)]   = ir;
  assign srcVal[int'(SRC_MEM)]  = memRdData;
  assign srcVal[int'(SRC_IN)]   = inReg;

  // one-hot AND-OR bus
  always_comb begin
    busVal = '0;
    for (int i = 0; i < SEL_N; i++)
      if (ctl.srcEn[i]) busVal = busVal | srcVal[i];
  end

  always_comb begin
    case (ctl.aluOp)
      ALU_ADD: aluRes = ac + mbr;
      ALU_SUB: aluRes = ac - mbr;
      default: aluRes = mbr;
    endcase
  end

  always_comb begin
    case (ctl.acSel)
      AC_ALU:  acNext = aluRes;
      AC_MBR:  acNext = mbr;
      AC_ONE:  acNext = DATA_W'(1);
      default: acNext = busVal;
    endcase
    acLoad = (ctl.acSel != AC_BUS) || ctl.dstEn[int'(DST_AC)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mar <= '0; pc <= '0; mbr <= '0; ac <= '0;
      ir <= '0; inReg <= '0; outReg <= '0;
    end else begin
      inReg <= inWord;
      if (ctl.dstEn[int'(DST_MAR)]) mar <= busVal[ADDR_W-1:0];
      if (ctl.dstEn[int'(DST_PC)])  pc  <= busVal[ADDR_W-1:0];
      else if (ctl.pcInc)           pc  <= pc + 1'b1;
      if (ctl.dstEn[int'(DST_MBR)]) mbr <= busVal;
      if (acLoad)                   ac  <= acNext;
      if (ctl.dstEn[int'(DST_IR)])  ir  <= busVal;
      if (ctl.dstEn[int'(DST_OUT)]) outReg <= busVal;
    end
  end

  assign memAddr   = mar;
  assign memWe     = ctl.dstEn[int'(DST_MEM)];
  assign memWrData = busVal;
  assign outWord   = outReg;
  assign acNeg     = ac[DATA_W-1];
  assign acZero    = (ac == '0);
  assign opcode    = ir[DATA_W-1 -: OP_W];

  // R7: increment steps PC by one when no bus load targets it
  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcInc && !ctl.dstEn[int'(DST_PC)]) |=> (pc == ADDR_W'($past(pc) + 1'b1)));
  // R3: unselected MAR holds
  assert_mar_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.dstEn[int'(DST_MAR)] |=> $stable(mar));
  // R12: output register holds unless addressed
  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.dstEn[int'(DST_OUT)] |=> $stable(outReg));
  // R12: no destination, no memory write
  assert_none_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dstEn[int'(DST_NONE)] |-> !memWe);
  // R5: constant-one side path
  assert_ac_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.acSel == AC_ONE) |=> (ac == DATA_W'(1)));
  // R9: flags never both set
  assert_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    acZero |-> !acNeg);
endmodule

// File: rtl/busdp_top.sv
`timescale 1ns/1ps
module busdp_top
  import busdp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               srcSel,
  input  logic [2:0]               dstSel,
  input  logic [1:0]               aluOp,
  input  logic [1:0]               acSel,
  input  logic                     pcInc,
  input  logic [DATA_W-1:0]        memRdData,
  input  logic [DATA_W-1:0]        inWord,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memWe,
  output logic [DATA_W-1:0]        memWrData,
  output logic [DATA_W-1:0]        outWord,
  output logic                     acNeg,
  output logic                     acZero,
  output logic [DATA_W-ADDR_W-1:0] opcode
);
  busCtl_t ctl;

  busdp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .dstSel(dstSel),
    .aluOp(aluOp), .acSel(acSel), .pcInc(pcInc), .ctl(ctl)
  );

  busdp_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData), .inWord(inWord),
    .memAddr(memAddr), .memWe(memWe), .memWrData(memWrData), .outWord(outWord),
    .acNeg(acNeg), .acZero(acZero), .opcode(opcode)
  );
endmodule

// File: tb/test_busdp_top.sv
`timescale 1ns/1ps
module test_busdp_top;
  logic clk = 0, rstN = 0;
  logic [2:0] srcSel = 0, dstSel = 0;
  logic [1:0] aluOp = 0, acSel = 0;
  logic pcInc = 0;
  logic [15:0] memRdData = 0, inWord = 0;
  logic [11:0] memAddr;
  logic memWe, acNeg, acZero;
  logic [15:0] memWrData, outWord;
  logic [3:0] opcode;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  busdp_top i_busdp_top (.*);

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with controls idle
  task automatic step(logic [2:0] s, logic [2:0] d, logic [1:0] a, logic [1:0] c, logic inc);
    srcSel = s; dstSel = d; aluOp = a; acSel = c; pcInc = inc;
    @(posedge clk); @(negedge clk);
    srcSel = 0; dstSel = 0; aluOp = 0; acSel = 0; pcInc = 0;
  endtask

  task automatic put(logic [15:0] v, logic [2:0] d);
    inWord = v;
    step(0, 0, 0, 0, 0);
    step(7, d, 0, 0, 0);
  endtask

  task automatic readOut(logic [2:0] s, output logic [15:0] v);
    step(s, 7, 0, 0, 0);
    v = outWord;
  endtask

  logic [15:0] r;
  logic [15:0] pats [6] = '{16'hFABC, 16'h8001, 16'h0000, 16'h7FFF, 16'h1234, 16'hFFFF};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 outWord", outWord, 0);
    chk("R1 acZero", {15'd0, acZero}, 1);
    chk("R1 acNeg", {15'd0, acNeg}, 0);
    chk("R1 opcode", {12'd0, opcode}, 0);
    chk("R1 memAddr", {4'd0, memAddr}, 0);
    chk("R1 memWe", {15'd0, memWe}, 0);
    readOut(2, r); chk("R1 PC", r, 0);
    readOut(3, r); chk("R1 MBR", r, 0);

    // R4, R2, R9, R10: register sweep
    for (int d = 1; d <= 5; d++) begin
      for (int k = 0; k < 6; k++) begin
        logic [15:0] e;
        put(pats[k], 3'(d));
        e = (d == 1 || d == 2) ? (pats[k] & 16'h0FFF) : pats[k];
        if (d == 1) chk("R4 memAddr", {4'd0, memAddr}, e);
        if (d == 4) begin
          chk("R9 acNeg", {15'd0, acNeg}, {15'd0, pats[k][15]});
          chk("R9 acZero", {15'd0, acZero}, {15'd0, pats[k] == 0});
        end
        if (d == 5) chk("R10 opcode", {12'd0, opcode}, {12'd0, pats[k][15:12]});
        readOut(3'(d), r); chk("R2/R4 readback", r, e);
      end
    end

    // R2 zero source, R11 input register
    put(16'h5A5A, 7); chk("R11 in->out", outWord, 16'h5A5A);
    readOut(0, r); chk("R2 zero source", r, 0);
    memRdData = 16'hC3C3; readOut(6, r); chk("R2 memory source", r, 16'hC3C3);

    // R3 isolation
    put(16'h0123, 1); put(16'h4444, 3); put(16'h0ABC, 2);
    chk("R3 MAR kept", {4'd0, memAddr}, 16'h0123);
    readOut(3, r); chk("R3 MBR kept", r, 16'h4444);
    readOut(2, r); chk("R3 PC", r, 16'h0ABC);

    // R12 destination none
    put(16'h2222, 4); put(16'h9000, 5);
    inWord = 16'hBEEF; step(0, 0, 0, 0, 0);
    srcSel = 7; dstSel = 0; #1;
    chk("R12 memWe", {15'd0, memWe}, 0);
    @(posedge clk); @(negedge clk); srcSel = 0;
    readOut(1, r); chk("R12 MAR", r, 16'h0123);
    readOut(2, r); chk("R12 PC", r, 16'h0ABC);
    readOut(3, r); chk("R12 MBR", r, 16'h4444);
    readOut(4, r); chk("R12 AC", r, 16'h2222);
    readOut(5, r); chk("R12 IR", r, 16'h9000);

    // R5 ALU sweep
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int op = 0; op < 4; op++) begin
          logic [15:0] e;
          put(pats[i], 4); put(pats[j], 3);
          step(0, 0, 2'(op), 1, 0);
          e = (op == 1) ? pats[i] + pats[j] : (op == 2) ? pats[i] - pats[j] : pats[j];
          readOut(4, r); chk("R5 alu", r, e);
        end
    put(16'h3333, 3); step(0, 0, 0, 2, 0); readOut(4, r); chk("R5 mbr path", r, 16'h3333);
    step(0, 0, 0, 3, 0); readOut(4, r); chk("R5 one", r, 1);
    put(16'h7777, 0); step(0, 0, 0, 0, 0); readOut(4, r); chk("R5 bus no dest", r, 1);

    // R6 side path with concurrent bus transfer
    put(16'h0100, 4); put(16'h0011, 3);
    step(4, 7, 1, 1, 0);
    chk("R6 old AC on bus", outWord, 16'h0100);
    readOut(4, r); chk("R6 AC sum", r, 16'h0111);
    inWord = 16'hAAAA; step(0, 0, 0, 0, 0);
    step(7, 4, 2, 1, 0);
    readOut(4, r); chk("R6 side path wins", r, 16'h0100);

    // R7 PC increment and wrap
    put(16'h0FFE, 2);
    step(0, 0, 0, 0, 1); readOut(2, r); chk("R7 inc", r, 16'h0FFF);
    step(0, 0, 0, 0, 1); readOut(2, r); chk("R7 wrap", r, 16'h0000);
    step(2, 7, 0, 0, 1); chk("R7 old PC on bus", outWord, 16'h0000);
    readOut(2, r); chk("R7 inc during transfer", r, 16'h0001);
    inWord = 16'h0500; step(0, 0, 0, 0, 0);
    step(7, 2, 0, 0, 1); readOut(2, r); chk("R7 load wins", r, 16'h0500);

    // R8 memory write
    put(16'h0456, 1);
    inWord = 16'h9876; step(0, 0, 0, 0, 0);
    srcSel = 7; dstSel = 6; #1;
    chk("R8 memWe", {15'd0, memWe}, 1);
    chk("R8 memWrData", memWrData, 16'h9876);
    chk("R8 memAddr", {4'd0, memAddr}, 16'h0456);
    @(posedge clk); @(negedge clk); srcSel = 0; dstSel = 0; #1;
    chk("R8 memWe low", {15'd0, memWe}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule